// File: doc/BRIEF.md
# Link Timer and Maskable Interrupt Unit

This block gives a fieldbus data-link controller three countdown timers and a single host interrupt line. The timers use fixed link-layer time bases: the octet time (eight pulses of the bit-rate strobe), a sub-millisecond tick every `div+1` system clocks, and a millisecond tick every 32 sub-millisecond ticks. Each timer reports expiry as an interrupt source.

Timer expiries and external event pulses from the receiver, transmitter and address matcher are captured in sticky pending bits. Each pending bit has its own enable bit. The registered interrupt output is high while any enabled bit is pending. The host reads the pending register to find the cause and clears bits by writing ones. A plain register port with a combinational read path and a single-cycle write strobe carries all configuration.

Top module: `link_timer_irq`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Pending register (address 0) layout: bit 0 = octet timer, bit 1 = sub-ms timer, bit 2 = ms timer, bit 3+k = `evt_in[k]`. A high `evt_in[k]` at a clock edge sets its bit, and the bit stays set until the host clears it.
- R3: Writing address 0 clears each pending bit whose data bit is 1 and leaves the others alone. An event arriving in the same cycle as the clear wins, and the bit stays set.
- R4: `irq` is registered. It goes high one clock after an enabled bit becomes pending, and low one clock after no enabled bit remains.
- R5: Enable register (address 1) uses the same bit layout as the pending register. A pending bit whose enable is 0 still reads back but does not drive `irq`.
- R6: Control register (address 2): bits [2:0] are per-timer run bits and bits [5:3] are per-timer auto-reload bits, in timer order. A stopped timer holds its count.
- R7: The octet timer steps once per 8 `bit_tick` pulses. The sub-ms timer steps every `div+1` clocks (divider at address 3). The ms timer steps every 32 sub-ms ticks.
- R8: A running timer whose count steps from 1 to 0 sets its pending bit. Without auto-reload it then stays at 0 and raises no further events.
- R9: With auto-reload set, the expiring step loads the timer's load value instead of 0, so expiries repeat every load value times the time base.
- R10: Writing a timer address (4, 5, 6) sets both its load value and its current count. Reading that address returns the current count. A load value of 0 never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| evt_in | input | N_EXT | Event pulses from other controller units |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| irq | output | 1 | Host interrupt, active high |

## Verification
The bench attacks the cycle where an event and a write-one-to-clear meet. A design that favours the clear would lose an interrupt there. It checks that a masked bit stays visible and that `irq` follows unmasking by exactly one clock; an unregistered or mis-gated output would show up early or not at all. It counts bit strobes across the 1-to-0 step of a one-shot timer and of a stopped timer, which exposes off-by-one expiry, re-firing at zero and decrementing while halted. It measures the repeat period of reloading sub-ms and ms timers, so a prescaler that is off by one clock or a wrong 32:1 ratio gives a wrong interval. Random event, clear and enable traffic is compared with a bench model of the pending and interrupt logic.

// File: rtl/link_timer_irq.sv
module link_timer_irq #(
  parameter int N_EXT = 5,
  parameter int DW    = 16,
  parameter int TW    = 16,
  parameter int SUBS  = 32,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic [N_EXT-1:0] evt_in,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq
);
  localparam int NS = 3 + N_EXT;
  localparam int SW = $clog2(SUBS);

  logic [NS-1:0] pend, mask, clr, evt_all;
  logic [2:0]    run, rl, tick, wr_t, expd;
  logic [DW-1:0] div, pcnt;
  logic [SW-1:0] scnt;
  logic [2:0]    bcnt;
  logic [TW-1:0] cnt  [3];
  logic [TW-1:0] load [3];
  logic          sub_t;

  assign sub_t   = (pcnt >= div);
  assign tick    = {sub_t && (scnt == SW'(SUBS-1)), sub_t, bit_tick && (bcnt == 3'd7)};
  assign clr     = (reg_wr && reg_addr == AW'(0)) ? reg_wdata[NS-1:0] : '0;
  assign evt_all = {evt_in, expd};

  always_comb
    for (int i = 0; i < 3; i++) begin
      wr_t[i] = reg_wr && (reg_addr == AW'(4 + i));
      expd[i] = run[i] && tick[i] && (cnt[i] == TW'(1)) && !wr_t[i];
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
      scnt <= '0;
      bcnt <= '0;
    end else begin
      pcnt <= sub_t ? '0 : pcnt + 1'b1;
      if (sub_t) scnt <= (scnt == SW'(SUBS-1)) ? '0 : scnt + 1'b1;
      if (bit_tick) bcnt <= bcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      mask  <= '0;
      run   <= '0;
      rl    <= '0;
      div   <= '0;
      irq   <= 1'b0;
    end else begin
      pend <= (pend & ~clr) | evt_all;
      irq  <= |(pend & mask);
      if (reg_wr && reg_addr == AW'(1)) mask <= reg_wdata[NS-1:0];
      if (reg_wr && reg_addr == AW'(2)) begin
        run <= reg_wdata[2:0];
        rl  <= reg_wdata[5:3];
      end
      if (reg_wr && reg_addr == AW'(3)) div <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (!rst_n) begin
        cnt[i]  <= '0;
        load[i] <= '0;
      end else if (wr_t[i]) begin
        cnt[i]  <= reg_wdata[TW-1:0];
        load[i] <= reg_wdata[TW-1:0];
      end else if (run[i] && tick[i] && cnt[i] != '0) begin
        if (cnt[i] == TW'(1)) cnt[i] <= rl[i] ? load[i] : '0;
        else                  cnt[i] <= cnt[i] - 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(0): reg_rdata = DW'(pend);
      AW'(1): reg_rdata = DW'(mask);
      AW'(2): reg_rdata = DW'({rl, run});
      AW'(3): reg_rdata = div;
      AW'(4): reg_rdata = DW'(cnt[0]);
      AW'(5): reg_rdata = DW'(cnt[1]);
      AW'(6): reg_rdata = DW'(cnt[2]);
      default: reg_rdata = '0;
    endcase
  end

  // R3
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend) & ~$past(clr)) & ~pend) == '0);
  // R3
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt_all) & ~pend) == '0);
  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(pend & mask)));
  // R4
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> !$past(|(pend & mask)));

  for (genvar g = 0; g < 3; g++) begin : g_tchk
    // R8
    oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(expd[g] && !rl[g]) |-> cnt[g] == '0);
    // R9
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(expd[g] && rl[g]) |-> cnt[g] == load[g]);
    // R10
    load_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_t[g]) |-> cnt[g] == $past(reg_wdata[TW-1:0]));
  end
endmodule

// File: tb/link_timer_irq_tb_top.sv
`timescale 1ns/1ps
module link_timer_irq_tb_top;
  localparam int N_EXT = 5;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int NS = 3 + N_EXT;

  logic clk = 0, rst_n = 0, bit_tick = 0, reg_wr = 0, irq;
  logic [N_EXT-1:0] evt_in = '0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  link_timer_irq dut_i (.clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .evt_in(evt_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = AW'(a); reg_wdata = DW'(d);
    @(negedge clk);
    reg_wr = 0; reg_addr = '0;
  endtask

  task automatic rd(int a, output logic [DW-1:0] v);
    reg_addr = AW'(a);
    #1 v = reg_rdata;
  endtask

  task automatic bits(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1;
      @(negedge clk); bit_tick = 0;
    end
  endtask

  function automatic logic [NS-1:0] next_pend(logic [NS-1:0] p, logic [NS-1:0] c, logic [N_EXT-1:0] e);
    return (p & ~c) | {e, 3'b000};
  endfunction

  // measures the interval between two irq rises; clears pending bit b after each rise
  task automatic period(int b, int ta, output int per, output logic [DW-1:0] cnt_at);
    int t0 = 0, t = 0, seen = 0;
    per = -1; cnt_at = '0;
    while (seen < 3 && t < 3000) begin
      @(negedge clk); t++;
      reg_wr = 0; reg_addr = AW'(ta);
      if (irq && !dut_prev_irq) begin
        seen++;
        #1 cnt_at = reg_rdata;
        if (seen == 2) t0 = t;
        if (seen == 3) per = t - t0;
        reg_wr = 1; reg_addr = '0; reg_wdata = DW'(1 << b);
      end
      dut_prev_irq = irq;
    end
    @(negedge clk); reg_wr = 0; reg_addr = '0;
  endtask

  logic dut_prev_irq = 0;

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    logic [NS-1:0] pend_m, mask_m, clr_m;
    logic irq_m;
    int per;
    void'($urandom(32'h1F3A));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(a, v); check("R1 reg", v, 0); end
    check("R1 irq", irq, 0);

    // R6 R7 R8 octet timer one-shot: load 3, run bit 0
    wr(4, 3); wr(2, 1);
    bits(23);
    rd(4, v); check("R7 octet count after 23 bits", v, 1);
    rd(0, v); check("R8 no early expiry", v, 0);
    bits(1);
    rd(4, v); check("R8 octet reaches zero", v, 0);
    rd(0, v); check("R2 octet pending bit0", v, 1);
    wr(0, 1);
    bits(8);
    rd(0, v); check("R8 one-shot stays quiet", v, 0);
    rd(4, v); check("R8 one-shot holds zero", v, 0);
    // R6 stopped timer holds count
    wr(2, 0); wr(4, 2);
    bits(16);
    rd(4, v); check("R6 stopped timer holds", v, 2);
    wr(2, 1);
    bits(8);
    rd(4, v); check("R6 running again steps", v, 1);
    // R10 load of zero never expires
    wr(4, 0);
    bits(16);
    rd(0, v); check("R10 zero load never fires", v, 0);
    wr(2, 0);

    // R3 event versus clear in same cycle
    @(negedge clk); evt_in = 5'b00001;
    @(negedge clk); evt_in = '0;
    rd(0, v); check("R2 ext event sets bit3", v, 8);
    @(negedge clk); evt_in = 5'b00001; reg_wr = 1; reg_addr = 0; reg_wdata = 16'h0008;
    @(negedge clk); evt_in = '0; reg_wr = 0;
    rd(0, v); check("R3 event beats clear", v, 8);
    wr(0, 16'h0010);
    rd(0, v); check("R3 clearing other bit leaves bit3", v, 8);

    // R5 masked pending, then unmask timing (R4)
    check("R5 masked bit gives no irq", irq, 0);
    wr(1, 8);
    check("R4 irq not yet at write+0", irq, 0);
    @(negedge clk);
    check("R4 irq one clock later", irq, 1);
    wr(0, 8);
    @(negedge clk);
    check("R4 irq drops after clear", irq, 0);

    // R7 R9 sub-ms timer: div 9, load 4, auto-reload
    wr(3, 9); wr(5, 4); wr(1, 2); wr(2, 16'h0012);
    dut_prev_irq = irq;
    period(1, 5, per, v);
    check("R7 sub-ms reload period", per, 40);
    check("R9 reloaded count", v, 4);
    wr(2, 0); wr(0, 16'hFF);
    // R7 R9 ms timer: load 1, auto-reload
    wr(6, 1); wr(1, 4); wr(2, 16'h0024);
    dut_prev_irq = irq;
    period(2, 6, per, v);
    check("R7 ms period is 32 sub ticks", per, 320);
    check("R9 ms reload value", v, 1);
    wr(2, 0); wr(0, 16'hFF); wr(1, 0);
    @(negedge clk);

    // R2 R3 R4 R5 random traffic against a bench model
    pend_m = '0; mask_m = '0; irq_m = 0;
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      @(negedge clk);
      check("R4 random irq", irq, irq_m);
      if (reg_addr == 0) check("R3 random pending", reg_rdata, DW'(pend_m));
      else check("R5 random enable", reg_rdata, DW'(mask_m));
      evt_in = N_EXT'($urandom & $urandom & $urandom);
      r = $urandom % 4;
      reg_wdata = DW'($urandom);
      reg_wr = (r < 2);
      reg_addr = (r == 1) ? 1 : 0;
      @(posedge clk);
      clr_m = (reg_wr && reg_addr == 0) ? reg_wdata[NS-1:0] : '0;
      irq_m = |(pend_m & mask_m);
      pend_m = next_pend(pend_m, clr_m, evt_in);
      if (reg_wr && reg_addr == 1) mask_m = reg_wdata[NS-1:0];
    end
    @(negedge clk); reg_wr = 0; evt_in = '0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule